// File: doc/BRIEF.md
# Overlaid Internal Data Memory

This block is the 256-byte on-chip data store of an 8-bit microcontroller core. Every cycle the core presents one access: a byte address, a mode (direct, indirect, register or bit), the two bank-select bits from its status word, a write enable and write data. The block turns the access into a physical byte location, or it routes it away to the special-function-register bus.

The top half of the address range is overlaid. A direct access to address 128 or above goes to the special-function registers. This block raises `sfr_sel` in the same cycle and leaves its RAM untouched. An indirect access to the same address reaches a second bank of 128 RAM bytes.

Register accesses reach four banks of eight registers at the bottom of the map. Bit accesses below bit address 128 reach sixteen bytes just above the register banks. A bit write updates one bit and leaves the other seven as they were. Read data is registered and appears one cycle after the access.

Top module: `idata_mem`

## Requirements
- R1: In register mode (`acc_mode`=2'b10) the byte used is `bank_sel`*8 + `addr[2:0]`. The upper address bits are ignored.
- R2: In bit mode (`acc_mode`=2'b11), a bit address n below 128 selects byte 32 + n/8, bit n mod 8. A bit read returns that bit on `rd_data[0]`, with `rd_data[7:1]` zero.
- R3: A bit write with n below 128 sets the selected bit to `wr_data[0]` and keeps the other seven bits of that byte unchanged.
- R4: Direct (`acc_mode`=2'b00) and indirect (`acc_mode`=2'b01) accesses to addresses 0 to 127 reach the same RAM bytes.
- R5: Indirect accesses to addresses 128 to 255 read and write the upper RAM, with `sfr_sel` low.
- R6: A direct access to addresses 128 to 255 drives `sfr_sel` high in the same cycle. A write does not change RAM, and `rd_data` is zero in the following cycle.
- R7: A bit access with n of 128 or more drives `sfr_sel` high, changes no RAM, and gives `rd_data` zero in the following cycle.
- R8: Read data appears on `rd_data` one cycle after the access. A write and a read of the same byte in the same cycle return the byte's previous contents.
- R9: While reset is held, and on the first cycle after it, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_mode | input | 2 | 00 direct, 01 indirect, 10 register, 11 bit |
| addr | input | 8 | Byte address, register index in [2:0], or bit address |
| bank_sel | input | 2 | Register bank from the status word |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 8 | Write byte; bit 0 is the bit value in bit mode |
| rd_data | output | 8 | Registered read data of the previous access |
| sfr_sel | output | 1 | High when the current access belongs to the special-function-register bus |

## Verification
A decoder fault sends an access to the wrong byte. The damage stays hidden in storage until that byte is read back through a different mode, so the bench writes in one mode and reads in another: register against direct, direct against indirect, bit against byte. A fault in the overlay shows at once on `sfr_sel`. It also shows one cycle later as non-zero `rd_data`, or as a corrupted upper RAM byte on the next indirect read. A faulty bit merge shows as changed neighbour bits on the very next byte read.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_INDIRECT = 2'b01,
    MODE_REGISTER = 2'b10,
    MODE_BIT      = 2'b11
  } acc_mode_e;
endpackage

// File: rtl/idata_rst_sync.sv
module idata_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/idata_addr_dec.sv
module idata_addr_dec
  import idata_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        acc_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [2:0]        bit_pos,
  output logic              bit_acc,
  output logic              ram_hit,
  output logic              sfr_hit
);
  localparam int REG_AREA = (1 << (BANK_W + REG_W));
  localparam int BIT_AREA = (1 << (ADDR_W - 1)) / 8;

  logic upper;
  assign upper = addr[ADDR_W-1];

  always_comb begin
    byte_addr = addr;
    bit_pos   = addr[2:0];
    bit_acc   = 1'b0;
    ram_hit   = 1'b1;
    sfr_hit   = 1'b0;
    unique case (acc_mode_e'(acc_mode))
      MODE_DIRECT: begin
        ram_hit = !upper;
        sfr_hit = upper;
      end
      MODE_INDIRECT: begin
        byte_addr = addr;
      end
      MODE_REGISTER: begin
        byte_addr = ADDR_W'({bank_sel, addr[REG_W-1:0]});
      end
      MODE_BIT: begin
        bit_acc   = 1'b1;
        byte_addr = ADDR_W'(BIT_BASE) + ADDR_W'(addr[ADDR_W-2:3]);
        ram_hit   = !upper;
        sfr_hit   = upper;
      end
      default: ;
    endcase
  end

  // R1: register accesses stay within the bank area
  assert_reg_in_banks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode == 2'b10) |-> (int'(byte_addr) < REG_AREA));
  // R2: low bit accesses stay within the bit area
  assert_bit_in_area_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode == 2'b11 && !addr[ADDR_W-1]) |->
      (int'(byte_addr) >= BIT_BASE && int'(byte_addr) < BIT_BASE + BIT_AREA));
  // R5: indirect never steers to the register bus
  assert_indirect_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode == 2'b01) |-> (ram_hit && !sfr_hit));
  // R6: direct upper accesses are steered away
  assert_direct_upper_sfr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode == 2'b00 && addr[ADDR_W-1]) |-> (sfr_hit && !ram_hit));
endmodule

// File: rtl/idata_store.sv
module idata_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [2:0]        bit_pos,
  input  logic              bit_acc,
  input  logic              ram_hit,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rows [DEPTH];
  logic [DATA_W-1:0] cur_byte;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] wr_byte;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rd_q;
  logic              wr_ram;

  assign cur_byte = rows[byte_addr];
  assign wr_ram   = wr_en && ram_hit;

  always_comb begin
    merged          = cur_byte;
    merged[bit_pos] = wr_data[0];
    wr_byte         = bit_acc ? merged : wr_data;
  end

  always_comb begin
    rd_next = '0;
    if (ram_hit) begin
      if (bit_acc) rd_next = DATA_W'(cur_byte[bit_pos]);
      else         rd_next = cur_byte;
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_row
    logic              row_we;
    logic [DATA_W-1:0] row_q;
    assign row_we = wr_ram && (byte_addr == ADDR_W'(k));
    always_ff @(posedge clk) begin
      if (row_we) row_q <= wr_byte;
    end
    assign rows[k] = row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_next;
  end

  assign rd_data = rd_q;

  // R6/R7: an access steered away yields zero read data next cycle
  assert_steer_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_hit |=> (rd_data == '0));
  // R2: bit reads return a single bit
  assert_bit_read_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_hit && bit_acc) |=> (rd_data[DATA_W-1:1] == '0));
endmodule

// File: rtl/idata_mem.sv
module idata_mem #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        acc_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              sfr_sel
);
  logic              rst_n_sync;
  logic [ADDR_W-1:0] byte_addr;
  logic [2:0]        bit_pos;
  logic              bit_acc;
  logic              ram_hit;
  logic              sfr_hit;

  idata_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  idata_addr_dec #(
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .REG_W    (REG_W),
    .BIT_BASE (BIT_BASE)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .acc_mode  (acc_mode),
    .addr      (addr),
    .bank_sel  (bank_sel),
    .byte_addr (byte_addr),
    .bit_pos   (bit_pos),
    .bit_acc   (bit_acc),
    .ram_hit   (ram_hit),
    .sfr_hit   (sfr_hit)
  );

  idata_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .byte_addr (byte_addr),
    .bit_pos   (bit_pos),
    .bit_acc   (bit_acc),
    .ram_hit   (ram_hit),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data)
  );

  assign sfr_sel = sfr_hit;

  // R7: bit addresses at or above 128 go to the register bus
  assert_bit_upper_sfr_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (acc_mode == 2'b11 && addr[ADDR_W-1]) |-> sfr_sel);
endmodule

// File: tb/idata_mem_bench.sv
module idata_mem_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] acc_mode;
  logic [7:0] addr;
  logic [1:0] bank_sel;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       sfr_sel;
  int total = 0;
  int bad   = 0;
  logic [7:0] got;
  logic       flag;

  always #2 clk = ~clk;

  idata_mem u_idata_mem (
    .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .addr(addr),
    .bank_sel(bank_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sfr_sel(sfr_sel)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one access at the falling edge; flag = sfr_sel in that cycle,
  // got = rd_data after the rising edge that captured it
  task automatic access(input logic [1:0] m, input logic [7:0] a, input logic [1:0] b,
                        input logic we, input logic [7:0] wd);
    @(negedge clk);
    acc_mode = m; addr = a; bank_sel = b; wr_en = we; wr_data = wd;
    #1 flag = sfr_sel;
    @(posedge clk);
    #1 got = rd_data;
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    acc_mode = 2'b01; addr = 8'h00; bank_sel = 2'b00; wr_en = 1'b0; wr_data = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R9 rd_data in reset", rd_data, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R9 rd_data after release", rd_data, 8'h00);
    repeat (3) @(posedge clk);
  endtask

  task automatic t_register();
    for (int b = 0; b < 4; b++)
      access(2'b10, 8'hF8 | 8'd5, 2'(b), 1'b1, 8'h40 + 8'(b));
    for (int b = 0; b < 4; b++) begin
      access(2'b00, 8'(b * 8 + 5), 2'b00, 1'b0, 8'h00);
      check("R1 bank register via direct", got, 8'h40 + 8'(b));
    end
  endtask

  task automatic t_low_ram();
    access(2'b00, 8'h50, 2'b00, 1'b1, 8'hC3);
    access(2'b01, 8'h50, 2'b00, 1'b0, 8'h00);
    check("R4 indirect sees direct write", got, 8'hC3);
    access(2'b01, 8'h7F, 2'b00, 1'b1, 8'h5A);
    access(2'b00, 8'h7F, 2'b00, 1'b0, 8'h00);
    check("R4 direct sees indirect write", got, 8'h5A);
  endtask

  task automatic t_upper();
    access(2'b01, 8'h90, 2'b00, 1'b1, 8'hA5);
    check("R5 indirect sfr_sel low", 8'(flag), 8'h00);
    access(2'b00, 8'h90, 2'b00, 1'b1, 8'h3C);
    check("R6 direct upper sfr_sel", 8'(flag), 8'h01);
    access(2'b00, 8'h90, 2'b00, 1'b0, 8'h00);
    check("R6 direct upper read zero", got, 8'h00);
    access(2'b01, 8'h90, 2'b00, 1'b0, 8'h00);
    check("R5 R6 upper RAM kept", got, 8'hA5);
  endtask

  task automatic t_bits();
    access(2'b00, 8'h25, 2'b00, 1'b1, 8'h00);
    access(2'b11, 8'h2B, 2'b00, 1'b1, 8'h01);
    access(2'b00, 8'h25, 2'b00, 1'b0, 8'h00);
    check("R2 R3 bit set lands in byte", got, 8'h08);
    access(2'b11, 8'h2B, 2'b00, 1'b0, 8'h00);
    check("R2 bit read one", got, 8'h01);
    access(2'b11, 8'h2A, 2'b00, 1'b0, 8'h00);
    check("R2 bit read zero", got, 8'h00);
    access(2'b00, 8'h2F, 2'b00, 1'b1, 8'hFF);
    access(2'b11, 8'h7F, 2'b00, 1'b1, 8'hFE);
    access(2'b00, 8'h2F, 2'b00, 1'b0, 8'h00);
    check("R3 bit clear keeps neighbours", got, 8'h7F);
  endtask

  task automatic t_bit_upper();
    access(2'b00, 8'h20, 2'b00, 1'b1, 8'h00);
    access(2'b11, 8'h80, 2'b00, 1'b1, 8'h01);
    check("R7 bit upper sfr_sel", 8'(flag), 8'h01);
    access(2'b11, 8'h80, 2'b00, 1'b0, 8'h00);
    check("R7 bit upper read zero", got, 8'h00);
    access(2'b00, 8'h20, 2'b00, 1'b0, 8'h00);
    check("R7 bit area untouched", got, 8'h00);
  endtask

  task automatic t_same_cycle();
    access(2'b00, 8'h40, 2'b00, 1'b1, 8'h11);
    access(2'b00, 8'h40, 2'b00, 1'b1, 8'h22);
    check("R8 same-cycle read old", got, 8'h11);
    access(2'b00, 8'h40, 2'b00, 1'b0, 8'h00);
    check("R8 next read new", got, 8'h22);
  endtask

  initial begin
    t_reset();
    t_register();
    t_low_ram();
    t_upper();
    t_bits();
    t_bit_upper();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule